// File: doc/BRIEF.md
# Per-Port Packet Traffic Statistics Monitor

This block sits beside one link port and watches the two packet streams that cross it, the one arriving (ingress) and the one leaving (egress). For each direction an upstream decoder hands it one descriptor per packet. The descriptor says whether the packet is a transaction-layer packet (TLP) or a data-link-layer packet (DLLP). For a TLP it also gives the ordering class, a type code and the payload size in dwords. For a DLLP it gives a small kind code. The block counts what it sees. It never drives the monitored streams.

Each direction has eight live counters. Three count TLP headers, one per class: posted, non-posted and completion. Three more add up payload dwords for the same classes. One counts TLPs that match a programmable class and type pair. One counts DLLPs that match a programmable kind selection. Software takes a consistent picture of all sixteen counters with one snapshot strobe, then reads the frozen copies one word at a time. A clear strobe zeroes the live counters. Rates and utilisation percentages are worked out in software from these raw counts.

Both streams are valid/ready links that belong to someone else. The monitor only observes them. A packet is counted on the cycle where its valid and ready are both high. The monitor has no ready output and cannot delay any beat. A beat where valid is high and ready is low is a stall on the monitored link and is not counted.

Top module: `tm_port_monitor`

## Requirements
- R1: A descriptor is counted only on a cycle where its direction's valid and ready are both high; a beat with valid high and ready low changes no counter.
- R2: Ingress events update only the ingress counters (read addresses 0 to 7). Egress events update only the egress counters (addresses 8 to 15). The block has no output toward either stream.
- R3: Every counted TLP adds one to the header counter of its class. The class encoding is 0 posted, 1 non-posted, 2 completion. Class 3 adds to no class counter.
- R4: Every counted TLP adds its dword length field to the dword counter of its class. A length of 0 means no payload and adds zero while the header still counts.
- R5: The filtered TLP counter adds one for a counted TLP whose class and type code both equal the filter class and filter type inputs, and ignores every other TLP.
- R6: The filtered DLLP counter follows the filter mode input. Mode 0 counts kind 0 (acknowledge). Mode 1 counts kind 1 (negative acknowledge). Mode 2 counts the flow-control update of the class given by the filter flow-control class input: kind 2 posted, kind 3 non-posted, kind 4 completion; that input set to 3 matches nothing. Mode 3 counts every DLLP.
- R7: A DLLP changes no TLP counter, and a TLP never changes the filtered DLLP counter.
- R8: Every counter is CNT_W bits wide and holds at its all-ones value instead of wrapping, including when a dword addition would overshoot.
- R9: A snapshot strobe copies all sixteen live counters, as they stood before that cycle's event, into shadow registers. rd_data shows the shadow word selected by rd_addr and does not change between snapshots.
- R10: A clear strobe zeroes all live counters. An event in the same cycle is counted starting from zero. A snapshot in the same cycle captures the values from before the clear.
- R11: After reset all live and shadow counters are zero. The read address is {direction, index}, with the index order: posted header, posted dwords, non-posted header, non-posted dwords, completion header, completion dwords, filtered TLP, filtered DLLP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ig_valid | input | 1 | Ingress stream valid (observed) |
| ig_ready | input | 1 | Ingress stream ready (observed) |
| ig_is_dllp | input | 1 | Ingress descriptor is a DLLP |
| ig_cls | input | 2 | Ingress TLP class |
| ig_kind | input | KIND_W (5) | Ingress TLP type code |
| ig_len | input | LEN_W (10) | Ingress TLP payload dwords |
| ig_dllp | input | 3 | Ingress DLLP kind code |
| eg_valid | input | 1 | Egress stream valid (observed) |
| eg_ready | input | 1 | Egress stream ready (observed) |
| eg_is_dllp | input | 1 | Egress descriptor is a DLLP |
| eg_cls | input | 2 | Egress TLP class |
| eg_kind | input | KIND_W (5) | Egress TLP type code |
| eg_len | input | LEN_W (10) | Egress TLP payload dwords |
| eg_dllp | input | 3 | Egress DLLP kind code |
| flt_cls | input | 2 | Filter class for the TLP filter |
| flt_kind | input | KIND_W (5) | Filter type code for the TLP filter |
| flt_dmode | input | 2 | DLLP filter mode |
| flt_fc_cls | input | 2 | Flow-control class for DLLP mode 2 |
| snap | input | 1 | Snapshot strobe |
| clr | input | 1 | Clear strobe |
| rd_addr | input | 4 | Shadow word select |
| rd_data | output | CNT_W (32) | Selected shadow counter |

## Verification
Software can read the live counters only through the shadow bank. A wrong increment, a missed saturation or a stray cross-direction update therefore shows up one cycle after the next snapshot, as a wrong word on rd_data. To catch this, every scenario ends with a snapshot and a sweep of all sixteen addresses against an independent model. That sweep also catches updates to counters the scenario did not target. Snapshot or clear mistakes show in the same cycle's capture: a shadow word that already includes a same-cycle event, or that misses the pre-clear value, differs right after that snapshot. A shadow that drifts without a snapshot shows on the reads taken before the next strobe.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic [1:0] {
    CLS_POSTED    = 2'd0,
    CLS_NONPOSTED = 2'd1,
    CLS_COMPL     = 2'd2,
    CLS_RSVD      = 2'd3
  } tlp_cls_e;

  localparam int DLLP_W = 3;
  localparam logic [DLLP_W-1:0] DL_ACK   = 3'd0;
  localparam logic [DLLP_W-1:0] DL_NAK   = 3'd1;
  localparam logic [DLLP_W-1:0] DL_UFC_P = 3'd2;

  localparam logic [1:0] DF_ACK = 2'd0;
  localparam logic [1:0] DF_NAK = 2'd1;
  localparam logic [1:0] DF_UFC = 2'd2;
  localparam logic [1:0] DF_ANY = 2'd3;

  localparam int NUM_CTR   = 8;
  localparam int IX_P_HDR  = 0;
  localparam int IX_P_DW   = 1;
  localparam int IX_NP_HDR = 2;
  localparam int IX_NP_DW  = 3;
  localparam int IX_C_HDR  = 4;
  localparam int IX_C_DW   = 5;
  localparam int IX_TFLT   = 6;
  localparam int IX_DFLT   = 7;
  localparam int NDIR      = 2;
endpackage

// File: rtl/tm_sat_counter.sv
module tm_sat_counter #(
  parameter int W  = 32,
  parameter int IW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc_en,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt
);
  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : cnt;
    sum  = {1'b0, base} + (W+1)'(inc);
    if (!inc_en)     nxt = base;
    else if (sum[W]) nxt = '1;
    else             nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/tm_dir_stats.sv
module tm_dir_stats
  import tm_pkg::*;
#(
  parameter int W      = 32,
  parameter int LEN_W  = 10,
  parameter int KIND_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  fire,
  input  logic                  is_dllp,
  input  logic [1:0]            cls,
  input  logic [KIND_W-1:0]     kind,
  input  logic [LEN_W-1:0]      len,
  input  logic [DLLP_W-1:0]     dllp,
  input  logic [1:0]            flt_cls,
  input  logic [KIND_W-1:0]     flt_kind,
  input  logic [1:0]            flt_dmode,
  input  logic [1:0]            flt_fc_cls,
  output logic [NUM_CTR*W-1:0]  cnt_flat
);
  logic               tlp_ev, dl_ev, dl_hit;
  logic [NUM_CTR-1:0] en;
  logic [LEN_W-1:0]   amt [NUM_CTR];

  assign tlp_ev = fire && !is_dllp;
  assign dl_ev  = fire && is_dllp;

  always_comb begin
    unique case (flt_dmode)
      DF_ACK:  dl_hit = (dllp == DL_ACK);
      DF_NAK:  dl_hit = (dllp == DL_NAK);
      DF_UFC:  dl_hit = (flt_fc_cls != 2'd3) &&
                        (dllp == DLLP_W'(DL_UFC_P + {1'b0, flt_fc_cls}));
      default: dl_hit = 1'b1;
    endcase
  end

  always_comb begin
    en = '0;
    for (int i = 0; i < NUM_CTR; i++) amt[i] = LEN_W'(1);
    en[IX_P_HDR]  = tlp_ev && (cls == CLS_POSTED);
    en[IX_P_DW]   = en[IX_P_HDR];
    en[IX_NP_HDR] = tlp_ev && (cls == CLS_NONPOSTED);
    en[IX_NP_DW]  = en[IX_NP_HDR];
    en[IX_C_HDR]  = tlp_ev && (cls == CLS_COMPL);
    en[IX_C_DW]   = en[IX_C_HDR];
    en[IX_TFLT]   = tlp_ev && (cls == flt_cls) && (kind == flt_kind);
    en[IX_DFLT]   = dl_ev && dl_hit;
    amt[IX_P_DW]  = len;
    amt[IX_NP_DW] = len;
    amt[IX_C_DW]  = len;
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    tm_sat_counter #(.W(W), .IW(LEN_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .inc_en (en[g]),
      .inc    (amt[g]),
      .cnt    (cnt_flat[g*W +: W])
    );
  end
endmodule

// File: rtl/tm_shadow_bank.sv
module tm_shadow_bank #(
  parameter int W   = 32,
  parameter int TOT = 16,
  localparam int AW = $clog2(TOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap,
  input  logic [TOT*W-1:0] live,
  input  logic [AW-1:0]    rd_addr,
  output logic [TOT*W-1:0] shadow,
  output logic [W-1:0]     rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)    shadow <= '0;
    else if (snap) shadow <= live;
  end

  assign rd_data = shadow[int'(rd_addr)*W +: W];
endmodule

// File: rtl/tm_port_monitor.sv
module tm_port_monitor
  import tm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 10,
  parameter int KIND_W = 5,
  localparam int TOT   = NDIR * NUM_CTR,
  localparam int AW    = $clog2(TOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ig_valid,
  input  logic              ig_ready,
  input  logic              ig_is_dllp,
  input  logic [1:0]        ig_cls,
  input  logic [KIND_W-1:0] ig_kind,
  input  logic [LEN_W-1:0]  ig_len,
  input  logic [2:0]        ig_dllp,
  input  logic              eg_valid,
  input  logic              eg_ready,
  input  logic              eg_is_dllp,
  input  logic [1:0]        eg_cls,
  input  logic [KIND_W-1:0] eg_kind,
  input  logic [LEN_W-1:0]  eg_len,
  input  logic [2:0]        eg_dllp,
  input  logic [1:0]        flt_cls,
  input  logic [KIND_W-1:0] flt_kind,
  input  logic [1:0]        flt_dmode,
  input  logic [1:0]        flt_fc_cls,
  input  logic              snap,
  input  logic              clr,
  input  logic [AW-1:0]     rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  logic [NDIR-1:0]     d_fire, d_dllp_f;
  logic [1:0]          d_cls  [NDIR];
  logic [KIND_W-1:0]   d_kind [NDIR];
  logic [LEN_W-1:0]    d_len  [NDIR];
  logic [DLLP_W-1:0]   d_code [NDIR];
  logic [TOT*CNT_W-1:0] live_flat;
  logic [TOT*CNT_W-1:0] shadow_flat;

  assign d_fire   = {eg_valid && eg_ready, ig_valid && ig_ready};
  assign d_dllp_f = {eg_is_dllp, ig_is_dllp};
  assign d_cls[0]  = ig_cls;   assign d_cls[1]  = eg_cls;
  assign d_kind[0] = ig_kind;  assign d_kind[1] = eg_kind;
  assign d_len[0]  = ig_len;   assign d_len[1]  = eg_len;
  assign d_code[0] = ig_dllp;  assign d_code[1] = eg_dllp;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    tm_dir_stats #(.W(CNT_W), .LEN_W(LEN_W), .KIND_W(KIND_W)) u_stats (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .fire       (d_fire[d]),
      .is_dllp    (d_dllp_f[d]),
      .cls        (d_cls[d]),
      .kind       (d_kind[d]),
      .len        (d_len[d]),
      .dllp       (d_code[d]),
      .flt_cls    (flt_cls),
      .flt_kind   (flt_kind),
      .flt_dmode  (flt_dmode),
      .flt_fc_cls (flt_fc_cls),
      .cnt_flat   (live_flat[d*NUM_CTR*CNT_W +: NUM_CTR*CNT_W])
    );
  end

  tm_shadow_bank #(.W(CNT_W), .TOT(TOT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .snap    (snap),
    .live    (live_flat),
    .rd_addr (rd_addr),
    .shadow  (shadow_flat),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/tm_port_monitor_chk.sv
module tm_port_monitor_chk #(
  parameter int W   = 32,
  parameter int TOT = 16,
  localparam int HALF = TOT * W / 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ig_valid,
  input logic             ig_ready,
  input logic             eg_valid,
  input logic             eg_ready,
  input logic             snap,
  input logic             clr,
  input logic [TOT*W-1:0] live_flat,
  input logic [TOT*W-1:0] shadow_flat
);
  logic ig_fire, eg_fire;
  assign ig_fire = ig_valid && ig_ready;
  assign eg_fire = eg_valid && eg_ready;

  // R1: no ingress handshake, no ingress counter change
  p_idle_ig_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ig_fire && !clr) |=> $stable(live_flat[HALF-1:0]));

  // R2: egress counters move only on egress handshakes
  p_idle_eg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eg_fire && !clr) |=> $stable(live_flat[TOT*W-1:HALF]));

  // R10: a clear with no event leaves everything at zero
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ig_fire && !eg_fire) |=> (live_flat == '0));

  // R9: snapshot captures pre-event live values
  p_snap_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (shadow_flat == $past(live_flat)));

  // R9: shadow holds between snapshots
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(shadow_flat));

  for (genvar i = 0; i < TOT; i++) begin : g_sat
    // R8: a full counter stays full unless cleared
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_flat[i*W +: W] == '1) && !clr) |=> (live_flat[i*W +: W] == '1));
  end
endmodule

bind tm_port_monitor tm_port_monitor_chk #(.W(CNT_W), .TOT(TOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ig_valid    (ig_valid),
  .ig_ready    (ig_ready),
  .eg_valid    (eg_valid),
  .eg_ready    (eg_ready),
  .snap        (snap),
  .clr         (clr),
  .live_flat   (live_flat),
  .shadow_flat (shadow_flat)
);

// File: tb/tm_port_monitor_tb.sv
module tm_port_monitor_tb;
  localparam int W    = 12;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic ig_valid = 0, ig_ready = 0, ig_is_dllp = 0;
  logic [1:0] ig_cls = 0;  logic [4:0] ig_kind = 0; logic [9:0] ig_len = 0; logic [2:0] ig_dllp = 0;
  logic eg_valid = 0, eg_ready = 0, eg_is_dllp = 0;
  logic [1:0] eg_cls = 0;  logic [4:0] eg_kind = 0; logic [9:0] eg_len = 0; logic [2:0] eg_dllp = 0;
  logic [1:0] flt_cls = 0; logic [4:0] flt_kind = 0; logic [1:0] flt_dmode = 0; logic [1:0] flt_fc_cls = 0;
  logic snap = 0, clr = 0;
  logic [3:0] rd_addr = 0;
  logic [W-1:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_live [16];
  int shd [16];

  always #4 clk = ~clk;

  tm_port_monitor #(.CNT_W(W), .LEN_W(10), .KIND_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ig_valid(ig_valid), .ig_ready(ig_ready), .ig_is_dllp(ig_is_dllp), .ig_cls(ig_cls),
    .ig_kind(ig_kind), .ig_len(ig_len), .ig_dllp(ig_dllp),
    .eg_valid(eg_valid), .eg_ready(eg_ready), .eg_is_dllp(eg_is_dllp), .eg_cls(eg_cls),
    .eg_kind(eg_kind), .eg_len(eg_len), .eg_dllp(eg_dllp),
    .flt_cls(flt_cls), .flt_kind(flt_kind), .flt_dmode(flt_dmode), .flt_fc_cls(flt_fc_cls),
    .snap(snap), .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic int sat(int a, int b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  function automatic bit dl_match(int code);
    case (flt_dmode)
      2'd0: return code == 0;
      2'd1: return code == 1;
      2'd2: return (flt_fc_cls != 2'd3) && (code == 2 + int'(flt_fc_cls));
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_evt(int dir, bit dl, int cls, int kind, int len, int code);
    int b = dir * 8;
    if (dl) begin
      if (dl_match(code)) exp_live[b+7] = sat(exp_live[b+7], 1);
    end else begin
      if (cls < 3) begin
        exp_live[b+2*cls]   = sat(exp_live[b+2*cls], 1);
        exp_live[b+2*cls+1] = sat(exp_live[b+2*cls+1], len);
      end
      if (cls == int'(flt_cls) && kind == int'(flt_kind)) exp_live[b+6] = sat(exp_live[b+6], 1);
    end
  endtask

  task automatic chk(string tag, int idx, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s addr %0d: actual %0d expected %0d", tag, idx, got, exp);
    end
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 16; i++) begin
      rd_addr = 4'(i);
      #1;
      chk(tag, i, int'(rd_data), shd[i]);
    end
  endtask

  // One cycle of stimulus; model order is snapshot, clear, then event.
  task automatic beat(int dir, bit vld, bit rdy, bit dl, int cls, int kind, int len, int code,
                      bit s = 0, bit c = 0);
    @(negedge clk);
    if (dir == 0) begin
      ig_valid = vld; ig_ready = rdy; ig_is_dllp = dl; ig_cls = 2'(cls);
      ig_kind = 5'(kind); ig_len = 10'(len); ig_dllp = 3'(code);
    end else begin
      eg_valid = vld; eg_ready = rdy; eg_is_dllp = dl; eg_cls = 2'(cls);
      eg_kind = 5'(kind); eg_len = 10'(len); eg_dllp = 3'(code);
    end
    snap = s; clr = c;
    if (s) for (int i = 0; i < 16; i++) shd[i] = exp_live[i];
    if (c) for (int i = 0; i < 16; i++) exp_live[i] = 0;
    if (vld && rdy) model_evt(dir, dl, cls, kind, len, code);
    @(negedge clk);
    ig_valid = 0; ig_ready = 0; eg_valid = 0; eg_ready = 0; snap = 0; clr = 0;
  endtask

  task automatic snap_check(string tag);
    beat(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    read_all(tag);
  endtask

  task automatic t_reset();
    read_all("R11 reset shadow");
    snap_check("R11 reset live");
  endtask

  task automatic t_posted();
    beat(0, 1, 1, 0, 0, 2, 4, 0);
    beat(0, 1, 1, 0, 0, 2, 16, 0);
    beat(1, 1, 1, 0, 0, 2, 1, 0);
    snap_check("R3 R2 posted per direction");
  endtask

  task automatic t_np_cpl();
    beat(0, 1, 1, 0, 1, 7, 0, 0);
    beat(1, 1, 1, 0, 1, 7, 0, 0);
    beat(0, 1, 1, 0, 2, 9, 8, 0);
    beat(1, 1, 1, 0, 2, 9, 0, 0);
    beat(0, 1, 1, 0, 3, 9, 5, 0);
    snap_check("R4 np/cpl and zero payload");
  endtask

  task automatic t_noready();
    beat(0, 1, 0, 0, 0, 2, 5, 0);
    beat(1, 1, 0, 1, 0, 0, 0, 0);
    beat(1, 0, 1, 0, 2, 0, 7, 0);
    snap_check("R1 stalled beats ignored");
  endtask

  task automatic t_tlp_filter();
    flt_cls = 2'd0; flt_kind = 5'd3;
    beat(0, 1, 1, 0, 0, 3, 2, 0);
    beat(0, 1, 1, 0, 0, 4, 2, 0);
    beat(0, 1, 1, 0, 1, 3, 0, 0);
    flt_cls = 2'd1;
    beat(1, 1, 1, 0, 1, 3, 0, 0);
    beat(1, 1, 1, 0, 0, 3, 1, 0);
    snap_check("R5 TLP filter");
  endtask

  task automatic t_dllp_filter();
    flt_dmode = 2'd0;
    beat(0, 1, 1, 1, 0, 0, 0, 0);
    beat(0, 1, 1, 1, 0, 0, 0, 1);
    flt_dmode = 2'd1;
    beat(1, 1, 1, 1, 0, 0, 0, 1);
    beat(1, 1, 1, 1, 0, 0, 0, 0);
    flt_dmode = 2'd2; flt_fc_cls = 2'd1;
    beat(0, 1, 1, 1, 0, 0, 0, 3);
    beat(0, 1, 1, 1, 0, 0, 0, 2);
    flt_fc_cls = 2'd2;
    beat(1, 1, 1, 1, 0, 0, 0, 4);
    flt_fc_cls = 2'd3;
    beat(1, 1, 1, 1, 0, 0, 0, 5);
    flt_dmode = 2'd3;
    beat(0, 1, 1, 1, 0, 0, 0, 7);
    beat(0, 1, 1, 0, 0, 0, 3, 0);
    snap_check("R6 R7 DLLP filter modes");
  endtask

  task automatic t_snap_hold();
    beat(0, 1, 1, 0, 2, 1, 6, 0);
    beat(1, 1, 1, 0, 0, 1, 2, 0);
    read_all("R9 shadow holds without snapshot");
    beat(0, 1, 1, 0, 0, 1, 9, 0, 1, 0);
    read_all("R9 snapshot excludes same-cycle event");
    snap_check("R9 next snapshot");
  endtask

  task automatic t_clear();
    beat(0, 1, 1, 0, 0, 1, 3, 0, 1, 1);
    read_all("R10 snapshot with clear keeps old values");
    beat(1, 1, 1, 0, 1, 1, 0, 0, 0, 1);
    snap_check("R10 clear then count from zero");
  endtask

  task automatic t_sat();
    for (int k = 0; k < 5; k++) beat(1, 1, 1, 0, 2, 0, 1023, 0);
    snap_check("R8 dword saturation");
    beat(1, 1, 1, 0, 2, 0, 1, 0);
    snap_check("R8 stays at maximum");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin exp_live[i] = 0; shd[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_posted();
    t_np_cpl();
    t_noready();
    t_tlp_filter();
    t_dllp_filter();
    t_snap_hold();
    t_clear();
    t_sat();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule